// File: doc/BRIEF.md
# CAN Bit Timing Synchronizer

This block turns the system clock into time quanta and steps a CAN node through the four parts of each bit: a one-quantum synchronization part, a propagation part, a first phase buffer and a second phase buffer. It samples the receive line once per bit, at the end of the first phase buffer. It reports that value with a one-cycle strobe. It also pulses a bit-start strobe that the transmit side uses to launch its next bit.

The block keeps in step with other nodes by watching for recessive-to-dominant transitions. The frame logic raises the hard-sync enable while the bus is idle. The first qualifying transition then restarts the bit outright. Inside a frame, a transition moves the sample point instead. It stretches the first phase buffer when the transition is late, or cuts the second phase buffer short when it is early. The size of that move is limited by the jump width. At most one such adjustment is accepted between two sample points.

Top module: `can_bt_sync`

## Requirements
- R1: With `half_clk_sel` low, one time quantum lasts `cfg_prescale` system clocks. `cfg_prescale` carries the count directly (1 to 32). When the bus has been recessive since reset, `bit_start` pulses every `cfg_prescale*(1+cfg_prop+cfg_phase1+cfg_phase2)` clocks.
- R2: With `half_clk_sel` high, the prescaler counts every second system clock, so every quantum and every bit period is twice as long as in R1.
- R3: A bit is laid out as one synchronization quantum, then `cfg_prop`, `cfg_phase1` and `cfg_phase2` quanta, each 1 to 8 and given directly. With no adjustment, `sample_strobe` follows `bit_start` by `cfg_prop+cfg_phase1` quanta. The two strobes are never high together.
- R4: While `rst` is high and after it, until the first quantum ends, `sample_strobe`, `bit_start` and `sync_event` are 0 and `sample_bit` is 1. Logic 1 is recessive and logic 0 is dominant.
- R5: `sample_bit` takes the level of `rx_raw`, delayed by a two-flop synchronizer, in the last quantum of the first phase buffer. It holds that value until the next sample.
- R6: A quantum counts as a synchronizing edge only when the last sampled bit was recessive and the synchronized line is dominant in that quantum.
- R7: If the edge falls in the synchronization quantum, no segment changes length, but `sync_event` still pulses.
- R8: If the edge falls in quantum n (n from 1) of the propagation or first phase part, the first phase buffer of that bit grows by min(n, `cfg_jump`). `cfg_jump` is 1 to 4 and is no larger than either phase buffer.
- R9: If the edge falls in the second phase buffer with m quanta left, counting the edge quantum, then: when m is at most `cfg_jump`, the edge quantum becomes the next bit's synchronization quantum. Otherwise the second phase buffer loses `cfg_jump` quanta and the remaining error is left.
- R10: When `hard_sync_en` is high, a qualifying edge anywhere in the bit makes its quantum the synchronization quantum of a new bit.
- R11: After one synchronization (hard or resync), further edges are ignored until the next sample point.
- R12: The strobes and `sync_event` are single-clock pulses. They are registered one clock after the prescaler edge that ends the quantum concerned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; configuration is changed only while it is high |
| rx_raw | input | 1 | Asynchronous receive line, 1 recessive |
| half_clk_sel | input | 1 | 1: prescaler fed from clock divided by two |
| cfg_prescale | input | 6 | Quantum length in prescaler clocks, 1 to 32 |
| cfg_prop | input | 4 | Propagation part length in quanta, 1 to 8 |
| cfg_phase1 | input | 4 | First phase buffer length in quanta, 1 to 8 |
| cfg_phase2 | input | 4 | Second phase buffer length in quanta, 1 to 8 |
| cfg_jump | input | 3 | Jump width in quanta, 1 to 4 |
| hard_sync_en | input | 1 | Frame logic allows a hard synchronization |
| sample_strobe | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Last sampled bus level |
| bit_start | output | 1 | One-clock pulse for the synchronization quantum of a bit |
| sync_event | output | 1 | One-clock pulse when a synchronization is accepted |

## Verification
The bench builds the block with the package defaults: a prescaler up to 32, segments up to 8, a jump width up to 4 and a two-stage receive synchronizer. It runs three runtime settings. The first is a short bit with a prescaler of 2. The second halves the clock with a prescaler of 1 and sets the jump width equal to both phase buffers, so every early edge is fully absorbed. The third uses the longest segments, a jump width of 1 and a prescaler of 3, so most errors are only partly corrected. In each setting, a dominant edge is placed at every clock offset within a bit. This reaches the synchronization quantum, every propagation and phase quantum, and the edges exactly at and just beyond the jump-width limit in both directions.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    localparam int unsigned MAX_BRP = 32;
    localparam int unsigned MAX_SEG = 8;
    localparam int unsigned MAX_SJW = 4;

    localparam int unsigned BRP_W = $clog2(MAX_BRP + 1);
    localparam int unsigned SEG_W = $clog2(MAX_SEG + 1);
    localparam int unsigned SJW_W = $clog2(MAX_SJW + 1);
    localparam int unsigned LEN_W = $clog2(MAX_SEG + MAX_SJW + 1);
    localparam int unsigned POS_W = $clog2(2 * MAX_SEG + MAX_SJW + 2);

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

    typedef struct packed {
        logic [SEG_W-1:0] prop;
        logic [SEG_W-1:0] ph1;
        logic [SEG_W-1:0] ph2;
        logic [SJW_W-1:0] sjw;
    } seg_cfg_t;

    typedef struct packed {
        logic strobe;
        logic bit_val;
        logic start;
        logic sync;
    } bt_out_t;

    // smaller of a positive phase error and the jump width
    function automatic logic [SJW_W-1:0] clip_jump(input logic [POS_W-1:0] err,
                                                   input logic [SJW_W-1:0] sjw);
        return (err < POS_W'(sjw)) ? SJW_W'(err) : sjw;
    endfunction

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             half_sel,
    input  logic [BRP_W-1:0] brp,
    output logic             tq_tick
);

    logic [BRP_W-1:0] cnt_q;
    logic             half_tgl_q;
    logic             base_en;

    assign base_en = !half_sel || half_tgl_q;

    always_comb begin
        tq_tick = base_en && (cnt_q == (brp - BRP_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            half_tgl_q <= 1'b0;
        end else begin
            half_tgl_q <= ~half_tgl_q;
            if (base_en) begin
                cnt_q <= tq_tick ? '0 : cnt_q + BRP_W'(1);
            end
        end
    end

    AST_CNT_BELOW_BRP: assert property (@(posedge clk) disable iff (rst)
        cnt_q < brp); // R1

    AST_HALF_GAP: assert property (@(posedge clk) disable iff (rst)
        (half_sel && tq_tick) |=> !tq_tick); // R2

endmodule

// File: rtl/can_bt_rxsync.sv
module can_bt_rxsync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    output logic rx_out
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], rx_in};
        end
    end

    assign rx_out = chain_q[STAGES-1];

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
    import can_bt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tq_tick,
    input  logic     rx_lvl,
    input  logic     hard_en,
    input  seg_cfg_t cfg,
    output bt_out_t  out_q
);

    seg_e             seg_q, seg_n;
    logic [LEN_W-1:0] idx_q, idx_n;
    logic [LEN_W-1:0] ph1_len_q, ph1_len_n;
    logic [LEN_W-1:0] ph2_len_q, ph2_len_n;
    logic             last_bit_q, last_bit_n;
    logic             synced_q, synced_n;
    bt_out_t          out_n;

    logic             edge_ok;
    logic             restart;
    logic [POS_W-1:0] pos;
    logic [SJW_W-1:0] ext;
    logic [LEN_W-1:0] mag;
    logic [LEN_W-1:0] prop_l, ph1_cfg, ph2_cfg, sjw_l;

    assign prop_l  = LEN_W'(cfg.prop);
    assign ph1_cfg = LEN_W'(cfg.ph1);
    assign ph2_cfg = LEN_W'(cfg.ph2);
    assign sjw_l   = LEN_W'(cfg.sjw);

    // quantum position inside the bit, Sync_Seg quantum = 0
    always_comb begin
        case (seg_q)
            SEG_PROP: pos = POS_W'(idx_q) + POS_W'(1);
            SEG_PH1:  pos = POS_W'(idx_q) + POS_W'(cfg.prop) + POS_W'(1);
            default:  pos = '0;
        endcase
    end

    assign ext     = clip_jump(pos, cfg.sjw);
    assign mag     = ph2_len_q - idx_q;
    assign edge_ok = tq_tick && !synced_q && last_bit_q && !rx_lvl;

    always_comb begin
        seg_n         = seg_q;
        idx_n         = idx_q;
        ph1_len_n     = ph1_len_q;
        ph2_len_n     = ph2_len_q;
        last_bit_n    = last_bit_q;
        synced_n      = synced_q;
        out_n         = '0;
        out_n.bit_val = out_q.bit_val;
        restart       = 1'b0;

        if (edge_ok) begin
            synced_n   = 1'b1;
            out_n.sync = 1'b1;
            if (hard_en) begin
                restart = 1'b1;
            end else begin
                case (seg_q)
                    SEG_PROP, SEG_PH1: ph1_len_n = ph1_len_q + LEN_W'(ext);
                    SEG_PH2: begin
                        if (mag <= sjw_l) restart = 1'b1;
                        else              ph2_len_n = ph2_len_q - sjw_l;
                    end
                    default: ;
                endcase
            end
        end

        if (tq_tick) begin
            if (restart) begin
                seg_n       = SEG_PROP;
                idx_n       = '0;
                ph1_len_n   = ph1_cfg;
                ph2_len_n   = ph2_cfg;
                out_n.start = 1'b1;
            end else begin
                case (seg_q)
                    SEG_SYNC: begin
                        out_n.start = 1'b1;
                        seg_n       = SEG_PROP;
                        idx_n       = '0;
                        ph1_len_n   = ph1_cfg;
                        ph2_len_n   = ph2_cfg;
                    end
                    SEG_PROP: begin
                        if (idx_q == prop_l - LEN_W'(1)) begin
                            seg_n = SEG_PH1;
                            idx_n = '0;
                        end else begin
                            idx_n = idx_q + LEN_W'(1);
                        end
                    end
                    SEG_PH1: begin
                        if (idx_q == ph1_len_n - LEN_W'(1)) begin
                            out_n.strobe  = 1'b1;
                            out_n.bit_val = rx_lvl;
                            last_bit_n    = rx_lvl;
                            synced_n      = 1'b0;
                            seg_n         = SEG_PH2;
                            idx_n         = '0;
                        end else begin
                            idx_n = idx_q + LEN_W'(1);
                        end
                    end
                    default: begin
                        if (idx_q == ph2_len_n - LEN_W'(1)) begin
                            seg_n = SEG_SYNC;
                            idx_n = '0;
                        end else begin
                            idx_n = idx_q + LEN_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q         <= SEG_SYNC;
            idx_q         <= '0;
            ph1_len_q     <= ph1_cfg;
            ph2_len_q     <= ph2_cfg;
            last_bit_q    <= 1'b1;
            synced_q      <= 1'b0;
            out_q         <= '0;
            out_q.bit_val <= 1'b1;
        end else begin
            seg_q      <= seg_n;
            idx_q      <= idx_n;
            ph1_len_q  <= ph1_len_n;
            ph2_len_q  <= ph2_len_n;
            last_bit_q <= last_bit_n;
            synced_q   <= synced_n;
            out_q      <= out_n;
        end
    end

    AST_SYNC_AFTER_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
        out_q.sync |-> last_bit_q); // R6

    AST_PH1_GROW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (int'(ph1_len_q) >= int'(cfg.ph1)) &&
        (int'(ph1_len_q) <= int'(cfg.ph1) + int'(cfg.sjw))); // R8

    AST_PH2_CUT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (int'(ph2_len_q) <= int'(cfg.ph2)) &&
        (int'(ph2_len_q) + int'(cfg.sjw) >= int'(cfg.ph2))); // R9

    AST_ONE_SYNC: assert property (@(posedge clk) disable iff (rst)
        out_q.sync |=> !out_q.sync); // R11

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(out_q.strobe && out_q.start)); // R3

endmodule

// File: rtl/can_bt_sync.sv
module can_bt_sync
    import can_bt_pkg::*;
#(
    parameter int unsigned RX_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_raw,
    input  logic             half_clk_sel,
    input  logic [BRP_W-1:0] cfg_prescale,
    input  logic [SEG_W-1:0] cfg_prop,
    input  logic [SEG_W-1:0] cfg_phase1,
    input  logic [SEG_W-1:0] cfg_phase2,
    input  logic [SJW_W-1:0] cfg_jump,
    input  logic             hard_sync_en,
    output logic             sample_strobe,
    output logic             sample_bit,
    output logic             bit_start,
    output logic             sync_event
);

    logic     tq_tick;
    logic     rx_lvl;
    seg_cfg_t seg_cfg;
    bt_out_t  bt_out;

    assign seg_cfg.prop = cfg_prop;
    assign seg_cfg.ph1  = cfg_phase1;
    assign seg_cfg.ph2  = cfg_phase2;
    assign seg_cfg.sjw  = cfg_jump;

    can_bt_prescaler u_presc (
        .clk      (clk),
        .rst      (rst),
        .half_sel (half_clk_sel),
        .brp      (cfg_prescale),
        .tq_tick  (tq_tick)
    );

    can_bt_rxsync #(.STAGES(RX_STAGES)) u_rxsync (
        .clk    (clk),
        .rst    (rst),
        .rx_in  (rx_raw),
        .rx_out (rx_lvl)
    );

    can_bt_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .tq_tick (tq_tick),
        .rx_lvl  (rx_lvl),
        .hard_en (hard_sync_en),
        .cfg     (seg_cfg),
        .out_q   (bt_out)
    );

    assign sample_strobe = bt_out.strobe;
    assign sample_bit    = bt_out.bit_val;
    assign bit_start     = bt_out.start;
    assign sync_event    = bt_out.sync;

endmodule

// File: tb/can_bt_sync_test.sv
module can_bt_sync_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic       half = 1'b0;
    logic [5:0] brp_p = 6'd2;
    logic [3:0] prop_p = 4'd2, p1_p = 4'd3, p2_p = 4'd3;
    logic [2:0] sjw_p = 3'd2;
    logic       hs = 1'b0;
    logic       smp, sbit, bst, sev;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    string tag = "R4";

    always #10 clk = ~clk;  // 50 MHz

    can_bt_sync uut (
        .clk(clk), .rst(rst), .rx_raw(rx), .half_clk_sel(half),
        .cfg_prescale(brp_p), .cfg_prop(prop_p), .cfg_phase1(p1_p),
        .cfg_phase2(p2_p), .cfg_jump(sjw_p), .hard_sync_en(hs),
        .sample_strobe(smp), .sample_bit(sbit), .bit_start(bst),
        .sync_event(sev)
    );

    // behavioural reference: quantum index within the bit
    int  c_brp, c_prop, c_p1, c_p2, c_sjw;
    bit  m_s1, m_s2, m_tg, m_last, m_syn;
    int  m_pc, m_q, m_p1e, m_be;
    bit  e_smp, e_bit, e_bs, e_ev;

    always @(posedge clk) begin
        bit en, tick, lvl, rs;
        int adj, mg;
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_tg = 0; m_pc = 0; m_q = 0;
            m_p1e = c_prop + c_p1; m_be = m_p1e + c_p2;
            m_last = 1; m_syn = 0;
            e_smp = 0; e_bit = 1; e_bs = 0; e_ev = 0;
        end else begin
            en   = !half || m_tg;
            tick = en && (m_pc == c_brp - 1);
            m_tg = !m_tg;
            if (en) m_pc = tick ? 0 : m_pc + 1;
            e_smp = 0; e_bs = 0; e_ev = 0;
            if (tick) begin
                lvl = m_s2;
                rs  = 0;
                if (!m_syn && m_last && !lvl) begin
                    m_syn = 1; e_ev = 1;
                    if (hs) rs = 1;
                    else if (m_q == 0) ;
                    else if (m_q <= m_p1e) begin
                        adj = (m_q < c_sjw) ? m_q : c_sjw;
                        m_p1e += adj; m_be += adj;
                    end else begin
                        mg = m_be - m_q + 1;
                        if (mg <= c_sjw) rs = 1;
                        else m_be -= c_sjw;
                    end
                end
                if (rs) begin
                    e_bs = 1; m_q = 1;
                    m_p1e = c_prop + c_p1; m_be = m_p1e + c_p2;
                end else begin
                    if (m_q == 0) e_bs = 1;
                    if (m_q == m_p1e) begin
                        e_smp = 1; e_bit = lvl; m_last = lvl; m_syn = 0;
                    end
                    if (m_q == m_be) begin
                        m_q = 0; m_p1e = c_prop + c_p1; m_be = m_p1e + c_p2;
                    end else m_q++;
                end
            end
            m_s2 = m_s1; m_s1 = rx;
        end
    end

    // per-cycle comparison away from the active edge
    int bs_last = 0, bs_gap = 0, ss_gap = 0;
    always @(negedge clk) begin
        cyc++;
        if (!rst && !done) begin
            checks += 4;
            if (smp !== e_smp) begin errors++;
                $display("FAIL %s/R3 sample_strobe act=%0b exp=%0b cyc=%0d", tag, smp, e_smp, cyc); end
            if (sbit !== e_bit) begin errors++;
                $display("FAIL %s/R5 sample_bit act=%0b exp=%0b cyc=%0d", tag, sbit, e_bit, cyc); end
            if (bst !== e_bs) begin errors++;
                $display("FAIL %s/R12 bit_start act=%0b exp=%0b cyc=%0d", tag, bst, e_bs, cyc); end
            if (sev !== e_ev) begin errors++;
                $display("FAIL %s sync_event act=%0b exp=%0b cyc=%0d", tag, sev, e_ev, cyc); end
            if (bst) begin bs_gap = cyc - bs_last; bs_last = cyc; end
            if (smp) ss_gap = cyc - bs_last;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            finish_run();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_bs();
        do @(negedge clk); while (!bst);
    endtask

    task automatic run_cfg(input int b, input bit h, input int pr, input int a1,
                           input int a2, input int j);
        int mult, nom;
        mult = h ? 2 : 1;
        nom  = b * (1 + pr + a1 + a2) * mult;
        @(negedge clk);
        rst = 1; rx = 1; hs = 0;
        c_brp = b; c_prop = pr; c_p1 = a1; c_p2 = a2; c_sjw = j;
        brp_p = 6'(b); half = h; prop_p = 4'(pr); p1_p = 4'(a1);
        p2_p = 4'(a2); sjw_p = 3'(j);
        idle(3);
        tag = "R4";
        check("R4 strobe in reset", int'(smp), 0);
        check("R4 bit_start in reset", int'(bst), 0);
        check("R4 sync_event in reset", int'(sev), 0);
        check("R4 sample_bit in reset", int'(sbit), 1);
        rst = 0;
        // idle bus: period and sample position
        tag = h ? "R2" : "R1";
        idle(6 * nom);
        check(h ? "R2 bit period" : "R1 bit period", bs_gap, nom);
        check("R3 sample offset", ss_gap, b * (pr + a1) * mult);
        // hard synchronization at an arbitrary phase
        tag = "R10";
        hs = 1;
        idle(7);
        rx = 0; idle(3 * nom);
        rx = 1; idle(2 * nom);
        hs = 0;
        // edges swept over every clock offset of a bit
        tag = "R7/R8/R9";
        for (int k = 0; k < nom; k++) begin
            wait_bs();
            idle(k);
            rx = 0; idle(nom);
            rx = 1; idle(2 * nom);
        end
        // drifting transmitter, alternating bits
        tag = "R8/R9 drift";
        for (int d = -3; d <= 3; d += 6) begin
            for (int i = 0; i < 10; i++) begin
                rx = i[0];
                idle(nom + d * b);
            end
            rx = 1; idle(3 * nom);
        end
        // short spikes and long dominant: one sync per sample interval
        tag = "R6/R11";
        for (int i = 0; i < 4; i++) begin
            wait_bs();
            idle(1 + i);
            rx = 0; idle(1); rx = 1;
            idle(b * mult + 1);
            rx = 0; idle(1); rx = 1;
            idle(3 * nom);
        end
        rx = 0; idle(4 * nom);
        rx = 1; idle(3 * nom);
    endtask

    initial begin
        c_brp = 2; c_prop = 2; c_p1 = 3; c_p2 = 3; c_sjw = 2;
        run_cfg(2, 1'b0, 2, 3, 3, 2);
        run_cfg(1, 1'b1, 1, 4, 4, 4);
        run_cfg(3, 1'b0, 8, 8, 8, 1);
        finish_run();
    end

endmodule